// File: doc/BRIEF.md
# Two-Branch Feistel AND-Rotate-XOR Block Encryptor

This block encrypts one 64-bit block, held as two 32-bit branches, at a rate of one full Feistel round per clock. It finishes a block in 44 rounds. Each round puts the upper branch through a nonlinear function built from rotations, a bitwise AND and a bitwise XOR. The result is XORed with the lower branch and with a round key, and it becomes the new upper branch. The old upper branch moves down to become the new lower branch. A one-bit mode input selects between two nonlinear functions of this family. Both functions share the register file and the Feistel swap.

The round keys are not generated inside the block. The core drives a round index, and the surrounding logic must return the 32-bit key for that round in the same cycle. A plaintext enters through a valid/ready handshake. While a block is in flight, ready stays low. A valid held high during that time is not a transfer and is not queued. The ciphertext output has no back-pressure: a one-cycle done pulse marks it, and the value stays on the output until the next accepted plaintext replaces it.

Top module: `ffx_encrypt`

## Requirements
- R1: While reset (synchronous, active high) is asserted, and in the first cycle after it, `done` is 0, `in_ready` is 1, `rk_idx` is 0 and `ct` is all zeros. This holds even if reset arrives in the middle of a block.
- R2: A plaintext is accepted on a rising edge where `in_valid` and `in_ready` are both 1. After that edge, `ct` equals the plaintext, with the upper branch in bits 63:32 and the lower branch in bits 31:0, and `in_ready` is 0.
- R3: With mode 0 captured, each round computes new_upper = g(U) ^ L ^ k and new_lower = U, where g(X) = (rotl(X,1) & rotl(X,8)) ^ rotl(X,2).
- R4: With mode 1 captured, the round is the same except that g(X) = (X & rotl(X,5)) ^ rotl(X,1).
- R5: `done` is 1 in exactly one cycle: the one that follows the 44th clock edge after the accepting edge. At that point `ct` holds {upper, lower} after 44 rounds, and `in_ready` is 1 again.
- R6: `rk_idx` is 0 in the cycle after acceptance and goes up by 1 each cycle through 43. The round applied at the end of the cycle in which `rk_idx` shows n uses the `rk` value present in that same cycle.
- R7: Once `done` has pulsed, `ct` stays unchanged until the next accepted plaintext.
- R8: While `in_ready` is 0, `in_valid` and `in_data` have no effect, and the block in flight finishes with its original result.
- R9: The mode is captured only at acceptance. Changing `in_mode` during a block does not change its result.
- R10: A new plaintext may be accepted in the same cycle that `done` is high, which gives back-to-back blocks with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Plaintext offered |
| in_ready | output | 1 | Core idle; a plaintext is accepted when valid is also high |
| in_data | input | 64 | Plaintext, upper branch in bits 63:32 |
| in_mode | input | 1 | Round-function select: 0 = rotations 1/8/2, 1 = rotations 0/5/1 |
| rk | input | 32 | Round key for the round named by rk_idx |
| rk_idx | output | 6 | Round currently being computed |
| ct | output | 64 | Branch state; the ciphertext once done has pulsed |
| done | output | 1 | One-cycle pulse when the ciphertext is valid |

## Verification
A wrong round function or a wrong key alignment does not show up on the ports until the 44th round, so the bench compares the whole ciphertext against an independent model at the done cycle. Because the branches are diffused, a single-bit slip in any round corrupts roughly half of the output bits. Control faults show sooner. A round index that does not advance, or that advances early, can be seen on `rk_idx` in the very next cycle. A miscounted round total moves the done pulse away from the 44th cycle. A leaking handshake or a late mode capture changes the result of a block that was sent with overlapping stimulus.

// File: rtl/ffx_pkg.sv
package ffx_pkg;

  typedef enum logic {
    FFX_MODE_WIDE   = 1'b0,
    FFX_MODE_NARROW = 1'b1
  } ffx_mode_e;

  localparam int FFX_NUM_MODES = 2;

  // Rotation amounts of the nonlinear function, per mode:
  // g(X) = (rotl(X,a) & rotl(X,b)) ^ rotl(X,c); sel 0 -> a, 1 -> b, 2 -> c
  function automatic int ffx_rot(input int mode, input int sel);
    int r;
    if (mode == 0) begin
      r = (sel == 0) ? 1 : (sel == 1) ? 8 : 2;
    end else begin
      r = (sel == 0) ? 0 : (sel == 1) ? 5 : 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/ffx_rotfn.sv
module ffx_rotfn #(
  parameter int W  = 32,
  parameter int RA = 1,
  parameter int RB = 8,
  parameter int RC = 2
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  localparam int RA_M = RA % W;
  localparam int RB_M = RB % W;
  localparam int RC_M = RC % W;

  logic [2*W-1:0] dbl;
  logic [W-1:0]   rot_a, rot_b, rot_c;

  always_comb begin
    dbl   = {x, x};
    rot_a = dbl[2*W-1-RA_M -: W];
    rot_b = dbl[2*W-1-RB_M -: W];
    rot_c = dbl[2*W-1-RC_M -: W];
    y     = (rot_a & rot_b) ^ rot_c;
  end
endmodule

// File: rtl/ffx_round.sv
module ffx_round
  import ffx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic      [W-1:0] up,
  input  logic      [W-1:0] lo,
  input  logic      [W-1:0] key,
  input  ffx_mode_e         mode,
  output logic      [W-1:0] up_nx,
  output logic      [W-1:0] lo_nx
);
  logic [W-1:0] g_all [FFX_NUM_MODES];
  logic [W-1:0] g_sel;

  for (genvar m = 0; m < FFX_NUM_MODES; m++) begin : g_mode
    ffx_rotfn #(
      .W (W),
      .RA(ffx_rot(m, 0)),
      .RB(ffx_rot(m, 1)),
      .RC(ffx_rot(m, 2))
    ) u_fn (
      .x(up),
      .y(g_all[m])
    );
  end

  always_comb begin
    g_sel = (mode == FFX_MODE_NARROW) ? g_all[1] : g_all[0];
    up_nx = g_sel ^ lo ^ key;
    lo_nx = up;
  end
endmodule

// File: rtl/ffx_ctrl.sv
module ffx_ctrl #(
  parameter int ROUNDS = 44,
  parameter int IDX_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS - 1);

  logic last_rnd;
  assign last_rnd = busy && (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
    end else begin
      done <= last_rnd;
      if (accept) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (last_rnd) begin
        busy <= 1'b0;
        idx  <= '0;
      end else if (busy) begin
        idx  <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ffx_encrypt.sv
module ffx_encrypt
  import ffx_pkg::*;
#(
  parameter  int HALF_W = 32,
  parameter  int ROUNDS = 44,
  localparam int BLK_W  = 2 * HALF_W,
  localparam int IDX_W  = $clog2(ROUNDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BLK_W-1:0]  in_data,
  input  logic              in_mode,
  input  logic [HALF_W-1:0] rk,
  output logic [IDX_W-1:0]  rk_idx,
  output logic [BLK_W-1:0]  ct,
  output logic              done
);
  logic              busy, accept;
  logic [HALF_W-1:0] up_q, lo_q, up_nx, lo_nx;
  ffx_mode_e         mode_q;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  ffx_ctrl #(
    .ROUNDS(ROUNDS),
    .IDX_W (IDX_W)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .accept(accept),
    .busy  (busy),
    .done  (done),
    .idx   (rk_idx)
  );

  ffx_round #(.W(HALF_W)) u_round (
    .up   (up_q),
    .lo   (lo_q),
    .key  (rk),
    .mode (mode_q),
    .up_nx(up_nx),
    .lo_nx(lo_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q   <= '0;
      lo_q   <= '0;
      mode_q <= FFX_MODE_WIDE;
    end else if (accept) begin
      up_q   <= in_data[BLK_W-1:HALF_W];
      lo_q   <= in_data[HALF_W-1:0];
      mode_q <= ffx_mode_e'(in_mode);
    end else if (busy) begin
      up_q   <= up_nx;
      lo_q   <= lo_nx;
    end
  end

  assign ct = {up_q, lo_q};
endmodule

// File: rtl/ffx_encrypt_chk.sv
module ffx_encrypt_chk #(
  parameter int HALF_W = 32,
  parameter int ROUNDS = 44,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2*HALF_W-1:0] in_data,
  input logic [IDX_W-1:0]  rk_idx,
  input logic [2*HALF_W-1:0] ct,
  input logic              done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS - 1);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!done && in_ready && rk_idx == '0 && ct == '0));

  a_r2_load_plaintext: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!in_ready && rk_idx == '0 && ct == $past(in_data)));

  a_r6_idx_steps: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && rk_idx != LAST) |=> (rk_idx == $past(rk_idx) + 1'b1));

  a_r8_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && rk_idx != LAST) |=> !in_ready);

  a_r5_done_after_last: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && rk_idx == LAST) |=> (done && in_ready));

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_ct_held: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> $stable(ct));
endmodule

bind ffx_encrypt ffx_encrypt_chk #(
  .HALF_W(HALF_W),
  .ROUNDS(ROUNDS),
  .IDX_W (IDX_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .in_data (in_data),
  .rk_idx  (rk_idx),
  .ct      (ct),
  .done    (done)
);

// File: tb/ffx_encrypt_bench.sv
`timescale 1ns/1ps
module ffx_encrypt_bench;
  localparam int NR = 44;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        in_mode = 1'b0;
  logic [31:0] rk;
  logic [5:0]  rk_idx;
  logic [63:0] ct;
  logic        done;

  logic [31:0] keys [NR];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ffx_encrypt u_ffx_encrypt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mode(in_mode), .rk(rk), .rk_idx(rk_idx),
    .ct(ct), .done(done)
  );

  assign rk = (rk_idx < NR) ? keys[rk_idx] : 32'h0;

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    return (n == 0) ? x : ((x << n) | (x >> (32 - n)));
  endfunction

  function automatic logic [63:0] model(input logic m, input logic [63:0] p);
    logic [31:0] u, l, t;
    u = p[63:32];
    l = p[31:0];
    for (int r = 0; r < NR; r++) begin
      t = u;
      if (!m) u = (rotl(u, 1) & rotl(u, 8)) ^ rotl(u, 2) ^ l ^ keys[r];
      else    u = (u & rotl(u, 5)) ^ rotl(u, 1) ^ l ^ keys[r];
      l = t;
    end
    return {u, l};
  endfunction

  task automatic set_keys(input logic [31:0] seed);
    logic [31:0] s;
    s = seed;
    for (int i = 0; i < NR; i++) begin
      s = s * 32'h9E3779B1 + 32'h7F4A7C15;
      keys[i] = s ^ {26'd0, 6'(i)};
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Accept a block at the next edge; return at the negedge after it
  task automatic send(input logic m, input logic [63:0] p);
    @(negedge clk);
    in_valid = 1'b1; in_data = p; in_mode = m;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Run a full block from the negedge after acceptance
  task automatic run_block(input logic m, input logic [63:0] p, input string req);
    logic [63:0] exp;
    exp = model(m, p);
    send(m, p);
    chk(ct == p && !in_ready, "R2", ct, p);
    for (int i = 1; i <= NR; i++) begin
      @(negedge clk);
      if (i < NR) begin
        if (done || rk_idx != 6'(i)) chk(0, "R6", 64'(rk_idx), 64'(i));
      end
    end
    chk(done && in_ready, "R5", {62'd0, done, in_ready}, 64'd3);
    chk(ct == exp, req, ct, exp);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    chk(!done && in_ready && rk_idx == 0 && ct == 0, "R1", ct, 64'd0);
  endtask

  task automatic t_mode0;
    set_keys(32'h1234_5678);
    run_block(1'b0, 64'h6565_6877_656E_6365, "R3");
    run_block(1'b0, 64'h0, "R3");
    run_block(1'b0, 64'hFFFF_FFFF_0000_0001, "R3");
  endtask

  task automatic t_mode1;
    set_keys(32'hCAFE_0001);
    run_block(1'b1, 64'h0123_4567_89AB_CDEF, "R4");
    run_block(1'b1, 64'h8000_0000_FFFF_FFFF, "R4");
  endtask

  task automatic t_done_and_hold;
    logic [63:0] held;
    set_keys(32'h0BAD_F00D);
    run_block(1'b0, 64'h1111_2222_3333_4444, "R3");
    held = ct;
    @(negedge clk);
    chk(!done, "R5", {63'd0, done}, 64'd0);
    repeat (5) @(negedge clk);
    chk(ct == held && !done, "R7", ct, held);
  endtask

  task automatic t_busy_ignored;
    logic [63:0] exp;
    set_keys(32'h5555_AAAA);
    exp = model(1'b0, 64'hDEAD_BEEF_0000_FFFF);
    send(1'b0, 64'hDEAD_BEEF_0000_FFFF);
    repeat (3) @(negedge clk);
    in_valid = 1'b1; in_data = 64'h0F0F_0F0F_F0F0_F0F0; in_mode = 1'b1;
    repeat (20) @(negedge clk);
    chk(!in_ready && rk_idx == 6'd23, "R8", 64'(rk_idx), 64'd23);
    repeat (20) @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(done && ct == exp, "R8", ct, exp);
    chk(done && ct == exp, "R9", ct, exp);
    in_mode = 1'b0;
  endtask

  task automatic t_back_to_back;
    logic [63:0] exp2;
    set_keys(32'h7777_1357);
    run_block(1'b1, 64'h2468_ACE0_1357_9BDF, "R4");
    in_valid = 1'b1; in_data = 64'hA5A5_5A5A_C3C3_3C3C; in_mode = 1'b0;
    exp2 = model(1'b0, in_data);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready && ct == 64'hA5A5_5A5A_C3C3_3C3C, "R10", ct,
        64'hA5A5_5A5A_C3C3_3C3C);
    repeat (NR) @(negedge clk);
    chk(done && ct == exp2, "R10", ct, exp2);
  endtask

  task automatic t_reset_midway;
    send(1'b0, 64'h1357_2468_1357_2468);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!done && in_ready && rk_idx == 0 && ct == 0, "R1", ct, 64'd0);
    repeat (40) @(negedge clk);
    chk(!done && ct == 0, "R1", ct, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_mode0();
    t_mode1();
    t_done_and_hold();
    t_busy_ignored();
    t_back_to_back();
    t_reset_midway();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule